// File: doc/BRIEF.md
# Multiplexed 8-bit Microcontroller Bus Master

This block acts as the master of a classic 8-bit microcontroller external memory bus. A host issues one command at a time through a small command port: a read, a write, a wait-for-pin-level, or a no-op. It supplies a 16-bit address, 8 bits of write data and, for the wait command, the level to wait for. The block runs the bus cycle and returns read data together with a one-clock completion pulse.

On the bus side the low address byte and the data share one 8-bit path. The path is given as separate output value, input value and output-enable signals, so that a pad ring can build the tristate. The high address byte has its own output. An address-latch strobe, an active-low select and active-low read and write strobes frame each access. The read and write strobe phase is stretched for as long as an external ready input is held low. The wait command stalls the command stream until a general-purpose input pin reaches a chosen level. This lets a peripheral's interrupt line decide when the host goes on to read it.

Phase lengths are parameters, counted in clock cycles. By default the address-latch strobe lasts 1 cycle, the address hold 1, the bus turnaround or write-data setup 1, the strobe 2 (minimum) and the data hold 1. The ready input and the wait pin each pass through a two-flop synchronizer.

Top module: `mbm_bus_master`

## Requirements
- R1: After reset, the latch strobe is low and select, read strobe and write strobe are high. Bus output-enable is low, done is low and cmd_ready_o is high.
- R2: Each read or write has exactly one cycle with the latch strobe high. In that cycle {addr_hi_o, ad_o} equals the command address and ad_oe_o is high.
- R3: Select is low in every cycle where the latch strobe is high or either data strobe is low.
- R4: On a write, ad_o carries the write data with ad_oe_o high during every write-strobe-low cycle. The same holds in the cycle after the write strobe rises, with select still low. The strobe is low for exactly 2 cycles when ready stays high.
- R5: On a read, ad_oe_o is low during every read-strobe-low cycle and in the cycle after the strobe rises. rdata_o returns the value on ad_i in the last strobe-low cycle. The strobe is low for exactly 2 cycles when ready stays high.
- R6: While ready (rdy_i) is low, the active strobe stays low. If ready rises after K strobe-low cycles (K at least 2), the strobe is low for exactly K+2 cycles, which accounts for the two-flop synchronizer.
- R7: Command op 2'b10 waits for wait_pin_i to equal cmd_level_i (1 = high, 0 = low). It creates no bus activity and raises no done while the pin differs. Done is seen 3 cycles after the pin changes to the requested level.
- R8: Done is a single-cycle pulse, given once per command. cmd_ready_o is low while a command is running, and a request raised then is ignored: it starts no second access.
- R9: Op encoding: 2'b00 read, 2'b01 write. Op 2'b11 is a no-op that gives done on the next cycle with no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | Command request, taken when cmd_ready_o is high |
| cmd_op_i | input | 2 | 00 read, 01 write, 10 wait for pin level, 11 no-op |
| cmd_addr_i | input | 16 | Access address |
| cmd_wdata_i | input | 8 | Write data |
| cmd_level_i | input | 1 | Pin level for the wait command |
| cmd_ready_o | output | 1 | High when idle |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Data from the last read |
| ad_o | output | 8 | Shared address/data bus, driven value |
| ad_i | input | 8 | Shared address/data bus, sampled value |
| ad_oe_o | output | 1 | Output enable for the shared bus |
| addr_hi_o | output | 8 | Address bits 15..8 |
| latch_o | output | 1 | Address latch strobe, active high |
| sel_n_o | output | 1 | Device select, active low |
| rstb_n_o | output | 1 | Read strobe, active low |
| wstb_n_o | output | 1 | Write strobe, active low |
| rdy_i | input | 1 | Ready; low stretches the strobe phase |
| wait_pin_i | input | 1 | Pin watched by the wait command |

## Verification
The bench models a peripheral. It drives read data derived from the latched address whenever the master's enable is low. A design that kept driving the bus into the read strobe shows up as contention. A design that dropped write data on the cycle the write strobe rises fails the hold check. Ready is released a set number of cycles into the strobe, and the exact strobe length is checked. This catches a missing synchronizer stage, and an exit that ignores ready or double-counts it. The wait command is tried at both levels with the pin held wrong for a long stretch. A design that compared the wrong polarity, or that completed before the pin changed, gives an early or late done. A request raised in mid-access must start no second access.

// File: rtl/mbm_pkg.sv
package mbm_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int HI_W   = ADDR_W - DATA_W;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_WAIT  = 2'b10,
        OP_NOP   = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LATCH,
        PH_AHOLD,
        PH_SETUP,
        PH_STRB,
        PH_DHOLD,
        PH_PINWAIT
    } phase_e;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              level;
    } req_t;

    typedef struct packed {
        logic              latch;
        logic              sel_n;
        logic              rstb_n;
        logic              wstb_n;
        logic              oe;
        logic [DATA_W-1:0] ad;
    } bus_t;

    function automatic logic is_access(input phase_e ph);
        return (ph == PH_LATCH) || (ph == PH_AHOLD) || (ph == PH_SETUP) ||
               (ph == PH_STRB)  || (ph == PH_DHOLD);
    endfunction

endpackage

// File: rtl/mbm_sync.sv
module mbm_sync #(
    parameter int               WIDTH   = 2,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk_i) begin
                if (rst_i) stage_q[s] <= RST_VAL;
                else       stage_q[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i) begin
                if (rst_i) stage_q[s] <= RST_VAL;
                else       stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/mbm_seq.sv
module mbm_seq
    import mbm_pkg::*;
#(
    parameter int LATCH_CYC = 1,
    parameter int AHOLD_CYC = 1,
    parameter int SETUP_CYC = 1,
    parameter int STRB_CYC  = 2,
    parameter int DHOLD_CYC = 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cmd_valid_i,
    input  req_t              cmd_i,
    input  logic              rdy_s_i,
    input  logic              pin_s_i,
    input  logic [DATA_W-1:0] ad_i,
    output bus_t              bus_o,
    output logic [HI_W-1:0]   addr_hi_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              done_o,
    output logic              idle_o
);

    localparam int LEN_SUM = LATCH_CYC + AHOLD_CYC + SETUP_CYC + STRB_CYC + DHOLD_CYC;
    localparam int CNT_W   = $clog2(LEN_SUM + 1);

    phase_e            phase_q, phase_d;
    req_t              req_q;
    logic [CNT_W-1:0]  cnt_q, len_m1;
    logic [DATA_W-1:0] rdata_q;
    logic              done_q, done_d, last, cap_rd;

    // Length of the current phase, minus one
    always_comb begin
        unique case (phase_q)
            PH_LATCH: len_m1 = CNT_W'(LATCH_CYC - 1);
            PH_AHOLD: len_m1 = CNT_W'(AHOLD_CYC - 1);
            PH_SETUP: len_m1 = CNT_W'(SETUP_CYC - 1);
            PH_STRB:  len_m1 = CNT_W'(STRB_CYC - 1);
            PH_DHOLD: len_m1 = CNT_W'(DHOLD_CYC - 1);
            default:  len_m1 = '0;
        endcase
    end

    assign last = (cnt_q == len_m1);

    always_comb begin
        phase_d = phase_q;
        done_d  = 1'b0;
        cap_rd  = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (cmd_valid_i) begin
                    unique case (cmd_i.op)
                        OP_READ, OP_WRITE: phase_d = PH_LATCH;
                        OP_WAIT:           phase_d = PH_PINWAIT;
                        default:           done_d  = 1'b1;
                    endcase
                end
            end
            PH_LATCH: if (last) phase_d = PH_AHOLD;
            PH_AHOLD: if (last) phase_d = PH_SETUP;
            PH_SETUP: if (last) phase_d = PH_STRB;
            PH_STRB: begin
                if (last && rdy_s_i) begin
                    phase_d = PH_DHOLD;
                    cap_rd  = (req_q.op == OP_READ);
                end
            end
            PH_DHOLD: begin
                if (last) begin
                    phase_d = PH_IDLE;
                    done_d  = 1'b1;
                end
            end
            PH_PINWAIT: begin
                if (pin_s_i == req_q.level) begin
                    phase_d = PH_IDLE;
                    done_d  = 1'b1;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            phase_q <= PH_IDLE;
            req_q   <= '0;
            cnt_q   <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            done_q  <= done_d;
            if (phase_q == PH_IDLE && cmd_valid_i) req_q <= cmd_i;
            if (phase_d != phase_q)  cnt_q <= '0;
            else if (!last)          cnt_q <= cnt_q + 1'b1;
            if (cap_rd)              rdata_q <= ad_i;
        end
    end

    // Bus pin decode from the registered phase
    always_comb begin
        logic wr, addr_ph;
        wr            = (req_q.op == OP_WRITE);
        addr_ph       = (phase_q == PH_LATCH) || (phase_q == PH_AHOLD);
        bus_o.latch   = (phase_q == PH_LATCH);
        bus_o.sel_n   = !is_access(phase_q);
        bus_o.rstb_n  = !((phase_q == PH_STRB) && (req_q.op == OP_READ));
        bus_o.wstb_n  = !((phase_q == PH_STRB) && wr);
        bus_o.oe      = addr_ph || (wr && is_access(phase_q));
        bus_o.ad      = addr_ph ? req_q.addr[DATA_W-1:0] : req_q.wdata;
    end

    assign addr_hi_o = req_q.addr[ADDR_W-1:DATA_W];
    assign rdata_o   = rdata_q;
    assign done_o    = done_q;
    assign idle_o    = (phase_q == PH_IDLE);

    AST_SEL_COVERS: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_o.latch || !bus_o.rstb_n || !bus_o.wstb_n) |-> !bus_o.sel_n); // R3
    AST_WDATA_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(bus_o.wstb_n) |-> (bus_o.oe && !bus_o.sel_n)); // R4
    AST_WSTB_DRIVEN: assert property (@(posedge clk_i) disable iff (rst_i)
        !bus_o.wstb_n |-> bus_o.oe); // R4
    AST_RD_NO_DRIVE: assert property (@(posedge clk_i) disable iff (rst_i)
        !bus_o.rstb_n |-> !bus_o.oe); // R5
    AST_RD_RELEASE: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(bus_o.rstb_n) |-> !bus_o.oe); // R5
    AST_STRB_STRETCH: assert property (@(posedge clk_i) disable iff (rst_i)
        ((!bus_o.rstb_n || !bus_o.wstb_n) && !rdy_s_i) |=> (!bus_o.rstb_n || !bus_o.wstb_n)); // R6
    AST_WAIT_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_q == PH_PINWAIT) |-> (bus_o.sel_n && !bus_o.latch)); // R7
    AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> idle_o); // R8

endmodule

// File: rtl/mbm_bus_master.sv
module mbm_bus_master
    import mbm_pkg::*;
#(
    parameter int LATCH_CYC   = 1,
    parameter int AHOLD_CYC   = 1,
    parameter int SETUP_CYC   = 1,
    parameter int STRB_CYC    = 2,
    parameter int DHOLD_CYC   = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cmd_valid_i,
    input  logic [1:0]        cmd_op_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic [DATA_W-1:0] cmd_wdata_i,
    input  logic              cmd_level_i,
    output logic              cmd_ready_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DATA_W-1:0] ad_o,
    input  logic [DATA_W-1:0] ad_i,
    output logic              ad_oe_o,
    output logic [HI_W-1:0]   addr_hi_o,
    output logic              latch_o,
    output logic              sel_n_o,
    output logic              rstb_n_o,
    output logic              wstb_n_o,
    input  logic              rdy_i,
    input  logic              wait_pin_i
);

    req_t       req;
    bus_t       bus;
    logic [1:0] sync_q;

    assign req.op    = op_e'(cmd_op_i);
    assign req.addr  = cmd_addr_i;
    assign req.wdata = cmd_wdata_i;
    assign req.level = cmd_level_i;

    // bit 1: ready (resets to not-ready), bit 0: wait pin
    mbm_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b00)
    ) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   ({rdy_i, wait_pin_i}),
        .q_o   (sync_q)
    );

    mbm_seq #(
        .LATCH_CYC (LATCH_CYC),
        .AHOLD_CYC (AHOLD_CYC),
        .SETUP_CYC (SETUP_CYC),
        .STRB_CYC  (STRB_CYC),
        .DHOLD_CYC (DHOLD_CYC)
    ) u_seq (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .cmd_valid_i (cmd_valid_i),
        .cmd_i       (req),
        .rdy_s_i     (sync_q[1]),
        .pin_s_i     (sync_q[0]),
        .ad_i        (ad_i),
        .bus_o       (bus),
        .addr_hi_o   (addr_hi_o),
        .rdata_o     (rdata_o),
        .done_o      (done_o),
        .idle_o      (cmd_ready_o)
    );

    assign latch_o  = bus.latch;
    assign sel_n_o  = bus.sel_n;
    assign rstb_n_o = bus.rstb_n;
    assign wstb_n_o = bus.wstb_n;
    assign ad_oe_o  = bus.oe;
    assign ad_o     = bus.ad;

endmodule

// File: tb/mbm_bus_master_tb.sv
module mbm_bus_master_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [15:0] cmd_addr;
    logic [7:0]  cmd_wdata;
    logic        cmd_level;
    logic        cmd_ready, done;
    logic [7:0]  rdata, ad_o, ad_i, addr_hi;
    logic        ad_oe, latch, sel_n, rstb_n, wstb_n;
    logic        rdy, pin;
    logic [15:0] ext_lat;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    mbm_bus_master u_dut (
        .clk_i(clk), .rst_i(rst), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
        .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata), .cmd_level_i(cmd_level),
        .cmd_ready_o(cmd_ready), .done_o(done), .rdata_o(rdata), .ad_o(ad_o),
        .ad_i(ad_i), .ad_oe_o(ad_oe), .addr_hi_o(addr_hi), .latch_o(latch),
        .sel_n_o(sel_n), .rstb_n_o(rstb_n), .wstb_n_o(wstb_n), .rdy_i(rdy),
        .wait_pin_i(pin)
    );

    // Peripheral model: external address latch, read data derived from it
    function automatic logic [7:0] periph_val(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    always @(negedge clk) if (latch) ext_lat <= {addr_hi, ad_o};
    assign ad_i = ad_oe ? ad_o : periph_val(ext_lat);

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Measurements from the last access
    int m_latch, m_rlow, m_wlow, m_bad_sel, m_bad_wd, m_bad_hold, m_bad_roe;
    int m_busy_ready, m_done_after, m_cycles;
    logic [15:0] m_addr;

    task automatic do_access(input logic [1:0] op, input logic [15:0] a,
                             input logic [7:0] wd, input int rel_k, input bit poke);
        bit pr = 0, pw = 0;
        m_latch = 0; m_rlow = 0; m_wlow = 0; m_bad_sel = 0; m_bad_wd = 0;
        m_bad_hold = 0; m_bad_roe = 0; m_busy_ready = 0; m_cycles = 0;
        if (rel_k >= 0) begin
            rdy = 1'b0;
            repeat (3) @(negedge clk);
        end
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = wd;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            m_cycles++;
            if (i == 0) cmd_valid = poke;
            if (poke && i == 0) cmd_addr = ~a;
            if (i == 3) cmd_valid = 1'b0;
            if (done) break;
            if (cmd_ready) m_busy_ready++;
            if (latch) begin
                m_latch++;
                m_addr = {addr_hi, ad_o};
                if (!ad_oe) m_bad_sel++;
            end
            if ((latch || !rstb_n || !wstb_n) && sel_n) m_bad_sel++;
            if (!rstb_n) begin
                m_rlow++;
                if (ad_oe) m_bad_roe++;
            end
            if (!wstb_n) begin
                m_wlow++;
                if (!ad_oe || ad_o != wd) m_bad_wd++;
            end
            if (pw && wstb_n && (!ad_oe || ad_o != wd || sel_n)) m_bad_hold++;
            if (pr && rstb_n && ad_oe) m_bad_roe++;
            if (rel_k >= 0 && rdy == 1'b0 && (m_rlow + m_wlow) == rel_k) rdy = 1'b1;
            pr = !rstb_n; pw = !wstb_n;
        end
        cmd_valid = 1'b0;
        @(negedge clk);
        m_done_after = done;
        rdy = 1'b1;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(!latch && sel_n && rstb_n && wstb_n, "R1", "strobes idle",
              {latch, sel_n, rstb_n, wstb_n}, 4'b0111);
        check(!ad_oe && !done && cmd_ready, "R1", "oe/done/ready",
              {ad_oe, done, cmd_ready}, 3'b001);
    endtask

    task automatic t_write(input logic [15:0] a, input logic [7:0] d);
        do_access(2'b01, a, d, -1, 1'b0);
        check(m_latch == 1 && m_addr == a, "R2", "write latch addr", m_addr, a);
        check(m_bad_sel == 0, "R3", "select framing on write", m_bad_sel, 0);
        check(m_wlow == 2 && m_bad_wd == 0 && m_bad_hold == 0, "R4", "write strobe/data",
              m_wlow * 256 + m_bad_wd * 16 + m_bad_hold, 2 * 256);
        check(m_rlow == 0, "R9", "op 01 is a write", m_rlow, 0);
    endtask

    task automatic t_read(input logic [15:0] a);
        do_access(2'b00, a, 8'h00, -1, 1'b0);
        check(m_latch == 1 && m_addr == a, "R2", "read latch addr", m_addr, a);
        check(m_rlow == 2 && m_bad_roe == 0 && m_wlow == 0, "R5", "read strobe/release",
              m_rlow * 16 + m_bad_roe, 2 * 16);
        check(rdata == periph_val(a), "R5", "read data", rdata, periph_val(a));
        check(m_bad_sel == 0, "R3", "select framing on read", m_bad_sel, 0);
    endtask

    task automatic t_stretch(input logic [1:0] op, input int k);
        do_access(op, 16'h1234 + 16'(k), 8'h3C, k, 1'b0);
        if (op == 2'b00)
            check(m_rlow == k + 2 && m_bad_roe == 0, "R6", "read stretch length", m_rlow, k + 2);
        else
            check(m_wlow == k + 2 && m_bad_wd == 0 && m_bad_hold == 0, "R6",
                  "write stretch length", m_wlow, k + 2);
    endtask

    task automatic t_busy;
        do_access(2'b01, 16'h5A0F, 8'h77, -1, 1'b1);
        check(m_latch == 1 && m_addr == 16'h5A0F, "R8", "busy request ignored", m_latch, 1);
        check(m_busy_ready == 0, "R8", "ready low while busy", m_busy_ready, 0);
        check(m_done_after == 0, "R8", "done single cycle", m_done_after, 0);
        repeat (3) @(negedge clk);
        check(!latch && sel_n && !done, "R8", "no second access", {latch, sel_n, done}, 3'b010);
    endtask

    task automatic t_wait(input logic lvl);
        int act = 0, n = 0;
        pin = !lvl;
        repeat (4) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b10; cmd_level = lvl;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (done || latch || !sel_n) act++;
            @(negedge clk);
        end
        check(act == 0 && !cmd_ready, "R7", "stalled while pin wrong", act, 0);
        pin = lvl;
        while (!done && n < 20) begin
            @(negedge clk);
            n++;
        end
        check(n == 3, "R7", "done delay after pin level", n, 3);
        @(negedge clk);
        check(!done && cmd_ready, "R8", "wait done one cycle", done, 0);
    endtask

    task automatic t_nop;
        int act = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b11;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(done == 1'b1, "R9", "no-op done next cycle", done, 1);
        if (latch || !sel_n || ad_oe) act++;
        @(negedge clk);
        if (latch || !sel_n || ad_oe || done) act++;
        check(act == 0, "R9", "no-op bus quiet", act, 0);
    endtask

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_addr = '0; cmd_wdata = '0;
        cmd_level = 1'b0; rdy = 1'b1; pin = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        repeat (3) @(negedge clk);
        t_write(16'hBEEF, 8'hC3);
        t_write(16'h0000, 8'hFF);
        t_read(16'hFFFF);
        t_read(16'h8001);
        t_stretch(2'b00, 5);
        t_stretch(2'b01, 2);
        t_stretch(2'b01, 9);
        t_busy();
        t_wait(1'b1);
        t_wait(1'b0);
        t_nop();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule